// File: doc/BRIEF.md
# USB Host Receive Endpoint Control and Status Register

This block holds the eight-bit control and status word of one receive endpoint in a USB host controller. Software reaches it through a plain register port: a write strobe with write data, and read data that always shows the current word. On the other side, the transaction engine reports one-cycle events: a good data packet, a corrupted data packet (CRC or bit-stuff fault), a STALL handshake, a NAK, and an attempt that ended with no data. The block turns these into status bits that hardware sets and software clears. It keeps request, flush and toggle-reset bits that software sets and hardware clears, and drives the matching strobes back to the engine and the receive FIFO.

The block tracks a two-slot receive buffer and shows whether a packet waits and whether the buffer is full. It counts failed attempts and measures how long an endpoint has been NAKed. In bulk mode a NAK run that is too long halts the endpoint until software acknowledges it. A one-cycle interrupt pulse marks each new stall, no-data error and ready packet.

Transfer type is an input: 2'b00 control, 2'b01 isochronous, 2'b10 bulk, 2'b11 interrupt. The word layout, from bit 7 down to bit 0, is: toggle reset, stall seen, IN request, flush, data error or NAK timeout, no-data error, buffer full, packet ready. The status bits are cleared by writing 0 to them, so software writes 1 to a status bit it wants to leave unchanged.

Top module: `usb_rx_ep_csr`

## Requirements
- R1: After reset the read word is 8'h00 and `irq`, `in_req`, `tog_clr`, `flush_stb` and `halted` are 0.
- R2: A write with bit 7 set makes bit 7 read 1 and pulses `tog_clr` for exactly one cycle, after which both return to 0. A write with bit 7 clear produces no pulse.
- R3: Status bits 6 (stall seen), 3 and 2 are set by hardware. A written 1 leaves them unchanged and a written 0 clears them. When a hardware set and a software clear of one bit fall in the same cycle, the bit ends up set. `ev_stall` sets bit 6.
- R4: A write with bit 5 set raises bit 5 and `in_req`, and a written 0 on bit 5 is ignored. The request drops in the cycle packet ready (bit 0) rises, or when a stall, a no-data error or a NAK timeout occurs.
- R5: The buffer holds two packets. Bit 1 reads 1 while both slots are occupied. A good packet that arrives while both slots are full, with no slot being released in that cycle, is discarded.
- R6: A good packet sets bit 0. Writing 0 to bit 0 while it is 1 releases one slot. If the other slot still holds a packet, bit 0 reads 0 for one cycle and then 1 again.
- R7: A write with bit 4 set makes bit 4 read 1 and pulses `flush_stb` for one cycle. In the next cycle one slot is released and bit 0 clears, so two flushes are needed to empty a full buffer.
- R8: A corrupted data packet sets bit 3 in every transfer type.
- R9: In bulk or interrupt mode, with the request pending, three consecutive no-data attempts set bit 2. The attempt count restarts on any data packet, good or corrupted, and on a new request. In isochronous mode bit 2 is never set and reads 0.
- R10: In bulk mode, with the request pending, a NAK starts a count of `frame_tick` pulses. When the count reaches `nak_limit`, bit 3 sets and `halted` rises. A limit of 0 disables the timeout, and any data packet or new request restarts the count.
- R11: While `halted` is 1, writes to bit 5 are ignored. Writing 0 to bit 3 clears `halted`.
- R12: `irq` is high for one cycle, in the first cycle that bit 6, bit 2 or bit 0 reads 1 after reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Current register word |
| xfer_type | input | 2 | Transfer type: 0 control, 1 iso, 2 bulk, 3 interrupt |
| nak_limit | input | NAK_W | NAK timeout in frames, 0 disables |
| frame_tick | input | 1 | One pulse per frame |
| ev_data_ok | input | 1 | Good data packet received |
| ev_data_err | input | 1 | Data packet with CRC or bit-stuff fault |
| ev_stall | input | 1 | STALL handshake received |
| ev_nak | input | 1 | NAK handshake received |
| ev_no_resp | input | 1 | Attempt ended with no data packet |
| in_req | output | 1 | IN transaction requested |
| tog_clr | output | 1 | Reset the data toggle to 0 |
| flush_stb | output | 1 | Discard the oldest buffered packet |
| halted | output | 1 | Endpoint halted after NAK timeout |
| irq | output | 1 | Interrupt pulse |

## Verification
The assertions take for granted that the engine raises at most one event per cycle and reports packets only when a slot can take them, or accepts that such a packet is dropped. They also assume `xfer_type` and `nak_limit` change only while no NAK count is running. The stimulus raises each event on its own cycle and changes mode and limit only between scenarios. The one deliberate collision, a stall arriving in the same cycle as a software clear, is driven as a single directed case. A behavioural model built on a packet queue and integer counters follows every cycle alongside the directed checks.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;
  localparam int B_TOG   = 7;
  localparam int B_STALL = 6;
  localparam int B_REQ   = 5;
  localparam int B_FLUSH = 4;
  localparam int B_NAKTO = 3;
  localparam int B_NODAT = 2;
  localparam int B_FULL  = 1;
  localparam int B_PRDY  = 0;

  typedef enum logic [1:0] {
    XFER_CTRL = 2'b00,
    XFER_ISO  = 2'b01,
    XFER_BULK = 2'b10,
    XFER_INTR = 2'b11
  } xfer_e;
endpackage

// File: rtl/usbrx_slot_track.sv
module usbrx_slot_track #(
  parameter int SLOTS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_req,
  input  logic release_req,
  output logic load_ok,
  output logic full,
  output logic nonempty
);
  localparam int OCC_W = $clog2(SLOTS + 1);

  logic [OCC_W-1:0] occ_q, occ_d;
  logic             rel_ok;
  logic             occ_en;

  always_comb begin
    rel_ok  = release_req && (occ_q != '0);
    load_ok = load_req && ((occ_q != OCC_W'(SLOTS)) || rel_ok);
    occ_d   = occ_q;
    if (rel_ok)  occ_d = occ_d - 1'b1;
    if (load_ok) occ_d = occ_d + 1'b1;
    occ_en  = rel_ok || load_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ_q <= '0;
    else if (occ_en) occ_q <= occ_d;
  end

  assign full     = (occ_q == OCC_W'(SLOTS));
  assign nonempty = (occ_q != '0);

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(SLOTS)); // R5
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    full && load_req && !release_req |=> full); // R5
endmodule

// File: rtl/usbrx_retry_mon.sv
module usbrx_retry_mon #(
  parameter int ATTEMPTS = 3,
  parameter int NAK_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             att_en,
  input  logic             no_resp,
  input  logic             nak_en,
  input  logic             nak_seen,
  input  logic             frame_tick,
  input  logic [NAK_W-1:0] nak_limit,
  output logic             nodata_hit,
  output logic             nak_hit
);
  localparam int ATT_W = $clog2(ATTEMPTS + 1);

  logic [ATT_W-1:0] att_q, att_d;
  logic             nact_q, nact_d;
  logic [NAK_W-1:0] ncnt_q, ncnt_d;
  logic             att_step, nak_step;

  // attempt counter
  always_comb begin
    att_step   = !restart && att_en && no_resp;
    nodata_hit = att_step && (att_q == ATT_W'(ATTEMPTS - 1));
    att_d      = att_q;
    if (restart)         att_d = '0;
    else if (nodata_hit) att_d = '0;
    else if (att_step)   att_d = att_q + 1'b1;
  end

  // NAK duration counter
  always_comb begin
    nak_step = nak_en && !restart && nact_q && frame_tick && (nak_limit != '0);
    nak_hit  = nak_step && ((ncnt_q + 1'b1) >= nak_limit);
    nact_d   = nact_q;
    ncnt_d   = ncnt_q;
    if (restart || !nak_en) begin
      nact_d = 1'b0;
      ncnt_d = '0;
    end else if (nak_hit) begin
      nact_d = 1'b0;
      ncnt_d = '0;
    end else begin
      if (nak_step) ncnt_d = ncnt_q + 1'b1;
      if (nak_seen) nact_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      att_q  <= '0;
      nact_q <= 1'b0;
      ncnt_q <= '0;
    end else begin
      att_q  <= att_d;
      nact_q <= nact_d;
      ncnt_q <= ncnt_d;
    end
  end

  AST_ATT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    att_q < ATT_W'(ATTEMPTS)); // R9
  AST_NAK_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    nak_hit |=> !nact_q && (ncnt_q == '0)); // R10
endmodule

// File: rtl/usb_rx_ep_csr.sv
module usb_rx_ep_csr
  import usbrx_pkg::*;
#(
  parameter int SLOTS    = 2,
  parameter int ATTEMPTS = 3,
  parameter int NAK_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic [7:0]       csr_wdata,
  output logic [7:0]       csr_rdata,
  input  logic [1:0]       xfer_type,
  input  logic [NAK_W-1:0] nak_limit,
  input  logic             frame_tick,
  input  logic             ev_data_ok,
  input  logic             ev_data_err,
  input  logic             ev_stall,
  input  logic             ev_nak,
  input  logic             ev_no_resp,
  output logic             in_req,
  output logic             tog_clr,
  output logic             flush_stb,
  output logic             halted,
  output logic             irq
);
  xfer_e xt;
  logic  bulk_int, bulk_only, is_iso;

  logic tog_q, stall_q, req_q, flush_q, nakto_q, nodat_q, prdy_q, halt_q, irq_q;
  logic tog_d, stall_d, req_d, flush_d, nakto_d, nodat_d, prdy_d, halt_d, irq_d;

  logic wclr_stall, wclr_nakto, wclr_nodat, wclr_prdy;
  logic release_req, load_ok, buf_full, buf_nonempty;
  logic req_new, restart, nodata_hit, nak_hit, prdy_rise, req_drop;

  assign xt        = xfer_e'(xfer_type);
  assign bulk_int  = (xt == XFER_BULK) || (xt == XFER_INTR);
  assign bulk_only = (xt == XFER_BULK);
  assign is_iso    = (xt == XFER_ISO);

  // software clear decode: a written 0 clears, a written 1 is ignored
  always_comb begin
    wclr_stall = csr_we && !csr_wdata[B_STALL];
    wclr_nakto = csr_we && !csr_wdata[B_NAKTO];
    wclr_nodat = csr_we && !csr_wdata[B_NODAT];
    wclr_prdy  = csr_we && !csr_wdata[B_PRDY] && prdy_q;
    release_req = wclr_prdy || flush_q;
    req_new    = csr_we && csr_wdata[B_REQ] && !halt_q;
    restart    = ev_data_ok || ev_data_err || req_new;
  end

  usbrx_slot_track #(.SLOTS(SLOTS)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_req   (ev_data_ok),
    .release_req(release_req),
    .load_ok    (load_ok),
    .full       (buf_full),
    .nonempty   (buf_nonempty)
  );

  usbrx_retry_mon #(.ATTEMPTS(ATTEMPTS), .NAK_W(NAK_W)) u_retry (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .att_en     (req_q && bulk_int),
    .no_resp    (ev_no_resp),
    .nak_en     (req_q && bulk_only && !halt_q),
    .nak_seen   (ev_nak),
    .frame_tick (frame_tick),
    .nak_limit  (nak_limit),
    .nodata_hit (nodata_hit),
    .nak_hit    (nak_hit)
  );

  // next state
  always_comb begin
    tog_d   = csr_we && csr_wdata[B_TOG];
    flush_d = csr_we && csr_wdata[B_FLUSH];
    stall_d = ev_stall || (stall_q && !wclr_stall);
    nakto_d = ev_data_err || nak_hit || (nakto_q && !wclr_nakto);
    halt_d  = nak_hit || (halt_q && !wclr_nakto);
    nodat_d = nodata_hit || (nodat_q && !wclr_nodat);
    prdy_d  = load_ok || (!release_req && buf_nonempty);
    prdy_rise = prdy_d && !prdy_q;
    req_drop  = prdy_rise || nodata_hit || nak_hit || ev_stall;
    if (req_drop)     req_d = 1'b0;
    else if (req_new) req_d = 1'b1;
    else              req_d = req_q;
    irq_d = (stall_d && !stall_q) || (nodat_d && !nodat_q) || prdy_rise;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q   <= 1'b0;
      stall_q <= 1'b0;
      req_q   <= 1'b0;
      flush_q <= 1'b0;
      nakto_q <= 1'b0;
      nodat_q <= 1'b0;
      prdy_q  <= 1'b0;
      halt_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      tog_q   <= tog_d;
      stall_q <= stall_d;
      req_q   <= req_d;
      flush_q <= flush_d;
      nakto_q <= nakto_d;
      nodat_q <= nodat_d;
      prdy_q  <= prdy_d;
      halt_q  <= halt_d;
      irq_q   <= irq_d;
    end
  end

  always_comb begin
    csr_rdata          = '0;
    csr_rdata[B_TOG]   = tog_q;
    csr_rdata[B_STALL] = stall_q;
    csr_rdata[B_REQ]   = req_q;
    csr_rdata[B_FLUSH] = flush_q;
    csr_rdata[B_NAKTO] = nakto_q;
    csr_rdata[B_NODAT] = nodat_q && !is_iso;
    csr_rdata[B_FULL]  = buf_full;
    csr_rdata[B_PRDY]  = prdy_q;
  end

  assign in_req    = req_q;
  assign tog_clr   = tog_q;
  assign flush_stb = flush_q;
  assign halted    = halt_q;
  assign irq       = irq_q;

  AST_TOG_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    tog_q && !(csr_we && csr_wdata[B_TOG]) |=> !tog_q); // R2
  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stall |=> stall_q); // R3
  AST_REQ_ENDS_ON_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prdy_q) |-> !req_q); // R4
  AST_FLUSH_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q && !(csr_we && csr_wdata[B_FLUSH]) |=> !flush_q); // R7
  AST_HALT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> !req_q); // R11
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($rose(stall_q) || $rose(nodat_q) || $rose(prdy_q))); // R12
endmodule

// File: tb/usb_rx_ep_csr_tb.sv
`timescale 1ns/1ps
module usb_rx_ep_csr_tb;
  localparam int SLOTS = 2;
  localparam int NAK_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             csr_we;
  logic [7:0]       csr_wdata;
  logic [7:0]       csr_rdata;
  logic [1:0]       xfer_type;
  logic [NAK_W-1:0] nak_limit;
  logic             frame_tick, ev_data_ok, ev_data_err, ev_stall, ev_nak, ev_no_resp;
  logic             in_req, tog_clr, flush_stb, halted, irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit running = 0;

  always #10 clk = ~clk;

  usb_rx_ep_csr #(.SLOTS(SLOTS), .ATTEMPTS(3), .NAK_W(NAK_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .xfer_type(xfer_type), .nak_limit(nak_limit), .frame_tick(frame_tick),
    .ev_data_ok(ev_data_ok), .ev_data_err(ev_data_err), .ev_stall(ev_stall),
    .ev_nak(ev_nak), .ev_no_resp(ev_no_resp),
    .in_req(in_req), .tog_clr(tog_clr), .flush_stb(flush_stb), .halted(halted), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int q[$];
  int pkt_id = 0;
  int m_att = 0, m_ncnt = 0;
  bit m_nact, m_tog, m_stall, m_req, m_flush, m_nakto, m_nodat, m_prdy, m_halt, m_irq;

  task automatic model_step();
    bit bi, bk, rel, acc, newreq, restart, ndh, nkh, nen;
    bit nst, nnto, nhalt, nnd, npr, nrq;
    int occ;
    bi = (xfer_type == 2'd2) || (xfer_type == 2'd3);
    bk = (xfer_type == 2'd2);
    occ = q.size();
    rel = ((csr_we && !csr_wdata[0] && m_prdy) || m_flush) && occ > 0;
    acc = ev_data_ok && (occ < SLOTS || rel);
    newreq = csr_we && csr_wdata[5] && !m_halt;
    restart = ev_data_ok || ev_data_err || newreq;
    ndh = 0; nkh = 0;
    if (restart) m_att = 0;
    else if (m_req && bi && ev_no_resp) begin
      m_att++;
      if (m_att == 3) begin ndh = 1; m_att = 0; end
    end
    nen = m_req && bk && !m_halt;
    if (restart || !nen) begin m_nact = 0; m_ncnt = 0; end
    else begin
      if (m_nact && frame_tick && nak_limit != 0) begin
        if (m_ncnt + 1 >= int'(nak_limit)) begin nkh = 1; m_nact = 0; m_ncnt = 0; end
        else m_ncnt++;
      end
      if (!nkh && ev_nak) m_nact = 1;
    end
    nst   = ev_stall || (m_stall && !(csr_we && !csr_wdata[6]));
    nnto  = ev_data_err || nkh || (m_nakto && !(csr_we && !csr_wdata[3]));
    nhalt = nkh || (m_halt && !(csr_we && !csr_wdata[3]));
    nnd   = ndh || (m_nodat && !(csr_we && !csr_wdata[2]));
    npr   = acc || (!rel && occ > 0);
    if ((npr && !m_prdy) || ndh || nkh || ev_stall) nrq = 0;
    else if (newreq) nrq = 1;
    else nrq = m_req;
    m_irq = (nst && !m_stall) || (nnd && !m_nodat) || (npr && !m_prdy);
    if (rel) void'(q.pop_front());
    if (acc) begin q.push_back(pkt_id); pkt_id++; end
    m_tog = csr_we && csr_wdata[7];
    m_flush = csr_we && csr_wdata[4];
    m_stall = nst; m_nakto = nnto; m_halt = nhalt; m_nodat = nnd; m_prdy = npr; m_req = nrq;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_att = 0; m_ncnt = 0; m_nact = 0; m_tog = 0; m_stall = 0; m_req = 0; m_flush = 0;
      m_nakto = 0; m_nodat = 0; m_prdy = 0; m_halt = 0; m_irq = 0;
    end else begin
      model_step();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    if (running && rst_n) begin
      chk("R2 bit7",  {31'd0, csr_rdata[7]}, {31'd0, m_tog});
      chk("R3 bit6",  {31'd0, csr_rdata[6]}, {31'd0, m_stall});
      chk("R4 bit5",  {31'd0, csr_rdata[5]}, {31'd0, m_req});
      chk("R7 bit4",  {31'd0, csr_rdata[4]}, {31'd0, m_flush});
      chk("R8 bit3",  {31'd0, csr_rdata[3]}, {31'd0, m_nakto});
      chk("R9 bit2",  {31'd0, csr_rdata[2]}, {31'd0, m_nodat && xfer_type != 2'd1});
      chk("R5 bit1",  {31'd0, csr_rdata[1]}, {31'd0, q.size() == SLOTS});
      chk("R6 bit0",  {31'd0, csr_rdata[0]}, {31'd0, m_prdy});
      chk("R12 irq",  {31'd0, irq},       {31'd0, m_irq});
      chk("R4 in_req",{31'd0, in_req},    {31'd0, m_req});
      chk("R2 tog_clr",{31'd0, tog_clr},  {31'd0, m_tog});
      chk("R7 flush_stb",{31'd0, flush_stb},{31'd0, m_flush});
      chk("R11 halted",{31'd0, halted},   {31'd0, m_halt});
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus helpers (called at posedge + 2) ----------------
  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [7:0] d);
    csr_we = 1'b1; csr_wdata = d;
    step();
    csr_we = 1'b0; csr_wdata = 8'h00;
  endtask

  task automatic pulse_ok();    ev_data_ok  = 1'b1; step(); ev_data_ok  = 1'b0; endtask
  task automatic pulse_err();   ev_data_err = 1'b1; step(); ev_data_err = 1'b0; endtask
  task automatic pulse_stall(); ev_stall    = 1'b1; step(); ev_stall    = 1'b0; endtask
  task automatic pulse_nak();   ev_nak      = 1'b1; step(); ev_nak      = 1'b0; endtask
  task automatic pulse_nr();    ev_no_resp  = 1'b1; step(); ev_no_resp  = 1'b0; endtask
  task automatic tick();        frame_tick  = 1'b1; step(); frame_tick  = 1'b0; endtask

  initial begin
    rst_n = 1'b0; csr_we = 0; csr_wdata = 0; xfer_type = 2'd2; nak_limit = 16'd4;
    frame_tick = 0; ev_data_ok = 0; ev_data_err = 0; ev_stall = 0; ev_nak = 0; ev_no_resp = 0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    running = 1;
    // R1 reset state
    chk("R1 rdata", {24'd0, csr_rdata}, 32'h00);
    chk("R1 outputs", {27'd0, irq, in_req, tog_clr, flush_stb, halted}, 32'h0);
    step();

    // R2 toggle reset
    wr(8'h80);
    chk("R2 bit7 set", {24'd0, csr_rdata}, 32'h80);
    chk("R2 tog_clr pulse", {31'd0, tog_clr}, 32'h1);
    step();
    chk("R2 self clear", {24'd0, csr_rdata}, 32'h00);
    wr(8'h00);
    chk("R2 no pulse on 0", {31'd0, tog_clr}, 32'h0);

    // R4 request, R12 interrupt on packet
    wr(8'h20);
    chk("R4 request set", {31'd0, in_req}, 32'h1);
    wr(8'h00);
    chk("R4 write 0 ignored", {31'd0, in_req}, 32'h1);
    pulse_ok();
    chk("R4 R6 packet ends request", {24'd0, csr_rdata}, 32'h01);
    chk("R12 irq on packet", {31'd0, irq}, 32'h1);
    step();
    chk("R12 one cycle", {31'd0, irq}, 32'h0);

    // R5 full and drop, R6 software release
    pulse_ok();
    chk("R5 full", {24'd0, csr_rdata}, 32'h03);
    pulse_ok();
    chk("R5 still full", {24'd0, csr_rdata}, 32'h03);
    wr(8'h00);
    chk("R6 gap after release", {24'd0, csr_rdata}, 32'h00);
    step();
    chk("R6 reasserts", {24'd0, csr_rdata}, 32'h01);
    chk("R12 irq on reassert", {31'd0, irq}, 32'h1);
    wr(8'h00);
    step();
    chk("R5 third packet dropped", {24'd0, csr_rdata}, 32'h00);

    // R7 flush twice
    pulse_ok(); pulse_ok();
    wr(8'h11);
    chk("R7 flush bit", {24'd0, csr_rdata}, 32'h13);
    chk("R7 flush strobe", {31'd0, flush_stb}, 32'h1);
    step();
    chk("R7 first flush", {24'd0, csr_rdata}, 32'h00);
    step();
    chk("R7 one left", {24'd0, csr_rdata}, 32'h01);
    wr(8'h11);
    step(); step();
    chk("R7 empty", {24'd0, csr_rdata}, 32'h00);

    // R3 stall status, R4 drop on stall
    pulse_stall();
    chk("R3 stall set", {24'd0, csr_rdata}, 32'h40);
    chk("R12 irq on stall", {31'd0, irq}, 32'h1);
    wr(8'h60);
    chk("R3 write 1 ignored", {24'd0, csr_rdata}, 32'h60);
    pulse_stall();
    chk("R4 stall ends request", {31'd0, in_req}, 32'h0);
    csr_we = 1'b1; csr_wdata = 8'h00; ev_stall = 1'b1;
    step();
    csr_we = 1'b0; ev_stall = 1'b0;
    chk("R3 hardware set wins", {24'd0, csr_rdata}, 32'h40);
    wr(8'h00);
    chk("R3 write 0 clears", {24'd0, csr_rdata}, 32'h00);

    // R8 data error
    pulse_err();
    chk("R8 data error", {24'd0, csr_rdata}, 32'h08);
    wr(8'h00);

    // R9 no-data error
    wr(8'h20);
    pulse_nr(); pulse_nr();
    chk("R9 two attempts", {24'd0, csr_rdata}, 32'h20);
    pulse_nr();
    chk("R9 third attempt", {24'd0, csr_rdata}, 32'h04);
    chk("R12 irq on nodata", {31'd0, irq}, 32'h1);
    wr(8'h00);
    wr(8'h20);
    pulse_nr(); pulse_nr(); pulse_err(); pulse_nr(); pulse_nr();
    chk("R9 restart on data", {24'd0, csr_rdata}, 32'h28);
    pulse_nr();
    chk("R9 count after restart", {24'd0, csr_rdata}, 32'h0C);
    wr(8'h00);
    xfer_type = 2'd1;
    wr(8'h20);
    pulse_nr(); pulse_nr(); pulse_nr(); step();
    chk("R9 iso never set", {24'd0, csr_rdata}, 32'h20);
    xfer_type = 2'd2;
    wr(8'h20);

    // R10 NAK timeout, R11 halt
    pulse_nak();
    tick(); tick(); tick();
    chk("R10 below limit", {31'd0, halted}, 32'h0);
    tick();
    chk("R10 timeout", {24'd0, csr_rdata}, 32'h08);
    chk("R10 halted", {31'd0, halted}, 32'h1);
    wr(8'h28);
    chk("R11 request blocked", {31'd0, in_req}, 32'h0);
    wr(8'h00);
    chk("R11 halt cleared", {31'd0, halted}, 32'h0);
    wr(8'h20);
    chk("R11 request after clear", {31'd0, in_req}, 32'h1);
    nak_limit = 16'd0;
    pulse_nak();
    repeat (6) tick();
    chk("R10 limit zero", {24'd0, csr_rdata}, 32'h20);
    nak_limit = 16'd4;
    pulse_err();
    pulse_nak(); tick(); tick(); tick();
    pulse_err();
    pulse_nak(); tick(); tick(); tick();
    chk("R10 restart on data", {31'd0, halted}, 32'h0);
    tick();
    chk("R10 timeout after restart", {31'd0, halted}, 32'h1);
    wr(8'h00);
    step(); step();

    running = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule